// File: doc/BRIEF.md
# Swept RAM Countdown Timer Bank

This block holds a large set of independent 32-bit countdown timers without giving each one its own counter. Every timer's state (current count, reload value, run flag and periodic flag) sits in one simple dual-port memory. A sequencer walks that memory one entry per clock, in ascending index order, and wraps around. In every visit it reads the entry, decrements a running timer and writes it back, so each timer advances once per sweep of `NUM_TIMERS` clocks. A sticky expired flag per timer is kept in flops so that it can be read as whole status words, and as one status slice per page of 16 timers.

A host issues one command at a time: load a value (and the periodic choice), start, stop, or reset a timer. The command is held until the sweep reaches the named timer, and is then applied in that timer's slot instead of the normal update. A single event output pulses for one clock with the timer index and a 2-bit kind when a timer expires, or when the host resets or stops a timer whose expired flag was set. A periodic timer reloads its period on expiry and keeps running by itself.

Top module: `sweep_timer_mgr`

## Requirements
- R1: After reset the block clears every memory entry over exactly `NUM_TIMERS` clocks. During this time `cmd_ready` is low and no event is raised. Afterwards all expired flags are zero.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the command has been applied, which takes at most `NUM_TIMERS` clocks.
- R3: The sweep visits one timer per clock in ascending index order and wraps from the last index to 0.
- R4: A timer loaded with V is started, and its start command completes at clock C. It expires at its V-th later visit, which raises an event of kind 1 with its index so that the event is seen at clock C + V*`NUM_TIMERS`. The expire sets its expired flag. A value of 0 acts as 1. A one-shot timer then stops and raises no further events.
- R5: A periodic timer reloads its period on expiry and keeps running. It raises an expire event every V*`NUM_TIMERS` clocks.
- R6: Op 2 (stop) clears the run flag. If the expired flag was set, the flag is cleared and an event of kind 3 is raised in the clock the command completes. Otherwise no event is raised.
- R7: Op 3 (reset) sets the count back to the reload value and sets the run flag. If the expired flag was set, the flag is cleared and an event of kind 2 is raised in the clock the command completes. Otherwise no event is raised.
- R8: Op 0 (load) sets the count and the reload value to `cmd_value` and the periodic flag to `cmd_periodic`, and clears the run flag. It leaves the expired flag untouched and raises no event. Op 1 (start) sets only the run flag.
- R9: A host command takes the slot of its timer's visit. That visit neither decrements nor expires the timer.
- R10: One clock after `stat_sel` is driven, `stat_word` bit b shows the expired flag of timer 32*`stat_sel`+b. One clock after `page_sel` is driven, `page_word` bit b shows the expired flag of timer 16*`page_sel`+b.
- R11: Each event is a single-clock pulse. Events of different timers on back-to-back clocks come out as separate pulses with their own indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 load, 1 start, 2 stop, 3 reset |
| cmd_idx | input | IDX_W (6) | Target timer |
| cmd_value | input | 32 | Count and reload value for load |
| cmd_periodic | input | 1 | Periodic choice for load |
| ev_valid | output | 1 | Event pulse |
| ev_idx | output | IDX_W (6) | Timer that raised the event |
| ev_kind | output | 2 | 1 expire, 2 reset of expired, 3 stop of expired |
| stat_sel | input | SEL_W (1) | Status word select |
| stat_word | output | 32 | Expired flags of the selected word |
| page_sel | input | PSEL_W (2) | Page select |
| page_word | output | 16 | Expired flags of the selected page |

## Verification
The bench measures the exact expiry clock against the completion of the start command. An off-by-one visit count would show as an error of a whole sweep, and so would an engine that let the host slot also decrement. A running periodic timer is restarted in mid-flight, so a design that did not drop the consumed visit keeps a two-sweep period where three are expected. Stop and reset are applied to both expired and unexpired timers, which catches events raised without a set flag and flags that are not cleared. A load onto an expired timer is checked to leave the status bit alone. Random timer indices, periods and modes cover word and page bit placement across both status words.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int unsigned TMR_CNT_W = 32;

  typedef logic [TMR_CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t count;
    cnt_t reload;
    logic run;
    logic periodic;
  } tmr_entry_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2,
    OP_RESET = 2'd3
  } tmr_op_e;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_EXPIRE = 2'd1,
    EV_RESET  = 2'd2,
    EV_STOP   = 2'd3
  } tmr_ev_e;
endpackage

// File: rtl/tmr_store.sv
module tmr_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic [AW-1:0]            rd_addr,
  output tmr_pkg::tmr_entry_t      rd_data,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  tmr_pkg::tmr_entry_t      wr_data
);
  tmr_pkg::tmr_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tmr_sweep.sv
module tmr_sweep #(
  parameter int unsigned NUM_TIMERS = 64,
  parameter int unsigned IDX_W      = $clog2(NUM_TIMERS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] ptr,
  output logic             init,
  output logic             s_vld,
  output logic [IDX_W-1:0] s_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_TIMERS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      init  <= 1'b1;
      s_vld <= 1'b0;
      s_idx <= '0;
    end else begin
      s_vld <= !init;
      s_idx <= ptr;
      ptr   <= (ptr == LAST) ? '0 : ptr + 1'b1;
      if (init && ptr == LAST) init <= 1'b0;
    end
  end

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (rst)
    s_vld && $past(s_vld) |-> s_idx == (($past(s_idx) == LAST) ? '0 : $past(s_idx) + 1'b1)); // R3
endmodule

// File: rtl/tmr_host.sv
module tmr_host #(
  parameter int unsigned NUM_TIMERS = 64,
  parameter int unsigned IDX_W      = $clog2(NUM_TIMERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_op,
  input  logic [IDX_W-1:0]     cmd_idx,
  input  tmr_pkg::cnt_t        cmd_value,
  input  logic                 cmd_periodic,
  input  logic                 s_vld,
  input  logic [IDX_W-1:0]     s_idx,
  output logic                 hit,
  output tmr_pkg::tmr_op_e     h_op,
  output tmr_pkg::cnt_t        h_value,
  output logic                 h_periodic
);
  logic             busy;
  logic [IDX_W-1:0] h_idx;
  logic [IDX_W:0]   wait_cnt;

  assign cmd_ready = !init && !busy;
  assign hit       = busy && s_vld && (h_idx == s_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      h_idx      <= '0;
      h_op       <= tmr_pkg::OP_LOAD;
      h_value    <= '0;
      h_periodic <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      busy       <= 1'b1;
      h_idx      <= cmd_idx;
      h_op       <= tmr_pkg::tmr_op_e'(cmd_op);
      h_value    <= cmd_value;
      h_periodic <= cmd_periodic;
    end else if (hit) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) wait_cnt <= '0;
    else              wait_cnt <= wait_cnt + 1'b1;
  end

  AST_HOST_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> wait_cnt < (IDX_W+1)'(NUM_TIMERS)); // R2
endmodule

// File: rtl/tmr_update.sv
module tmr_update (
  input  logic                 s_vld,
  input  logic                 hit,
  input  tmr_pkg::tmr_op_e     h_op,
  input  tmr_pkg::cnt_t        h_value,
  input  logic                 h_periodic,
  input  tmr_pkg::tmr_entry_t  cur,
  input  logic                 cur_exp,
  output logic                 we,
  output tmr_pkg::tmr_entry_t  nxt,
  output logic                 exp_set,
  output logic                 exp_clr,
  output tmr_pkg::tmr_ev_e     kind
);
  import tmr_pkg::*;

  always_comb begin
    nxt     = cur;
    we      = 1'b0;
    exp_set = 1'b0;
    exp_clr = 1'b0;
    kind    = EV_NONE;
    if (s_vld) begin
      if (hit) begin
        we = 1'b1;
        case (h_op)
          OP_LOAD: begin
            nxt.count    = h_value;
            nxt.reload   = h_value;
            nxt.periodic = h_periodic;
            nxt.run      = 1'b0;
          end
          OP_START: nxt.run = 1'b1;
          OP_STOP: begin
            nxt.run = 1'b0;
            if (cur_exp) begin
              exp_clr = 1'b1;
              kind    = EV_STOP;
            end
          end
          default: begin
            nxt.count = cur.reload;
            nxt.run   = 1'b1;
            if (cur_exp) begin
              exp_clr = 1'b1;
              kind    = EV_RESET;
            end
          end
        endcase
      end else if (cur.run) begin
        we = 1'b1;
        if (cur.count <= TMR_CNT_W'(1)) begin
          exp_set = 1'b1;
          kind    = EV_EXPIRE;
          if (cur.periodic) begin
            nxt.count = cur.reload;
          end else begin
            nxt.count = '0;
            nxt.run   = 1'b0;
          end
        end else begin
          nxt.count = cur.count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sweep_timer_mgr.sv
module sweep_timer_mgr #(
  parameter int unsigned NUM_TIMERS = 64,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned PAGE_SIZE  = 16,
  localparam int unsigned IDX_W     = $clog2(NUM_TIMERS),
  localparam int unsigned NW        = NUM_TIMERS / WORD_W,
  localparam int unsigned NP        = NUM_TIMERS / PAGE_SIZE,
  localparam int unsigned SEL_W     = (NW > 1) ? $clog2(NW) : 1,
  localparam int unsigned PSEL_W    = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [1:0]                    cmd_op,
  input  logic [IDX_W-1:0]              cmd_idx,
  input  logic [tmr_pkg::TMR_CNT_W-1:0] cmd_value,
  input  logic                          cmd_periodic,
  output logic                          ev_valid,
  output logic [IDX_W-1:0]              ev_idx,
  output logic [1:0]                    ev_kind,
  input  logic [SEL_W-1:0]              stat_sel,
  output logic [WORD_W-1:0]             stat_word,
  input  logic [PSEL_W-1:0]             page_sel,
  output logic [PAGE_SIZE-1:0]          page_word
);
  import tmr_pkg::*;

  logic [IDX_W-1:0] ptr, s_idx;
  logic             init, s_vld, hit, h_periodic;
  tmr_op_e          h_op;
  cnt_t             h_value;
  tmr_entry_t       rd_entry, upd_entry, wr_entry;
  logic             upd_we, wr_en, exp_set, exp_clr;
  logic [IDX_W-1:0] wr_addr;
  tmr_ev_e          kind;
  logic [NUM_TIMERS-1:0] exp_q;

  tmr_sweep #(.NUM_TIMERS(NUM_TIMERS), .IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst(rst), .ptr(ptr), .init(init), .s_vld(s_vld), .s_idx(s_idx));

  tmr_host #(.NUM_TIMERS(NUM_TIMERS), .IDX_W(IDX_W)) u_host (
    .clk(clk), .rst(rst), .init(init), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_value(cmd_value), .cmd_periodic(cmd_periodic),
    .s_vld(s_vld), .s_idx(s_idx), .hit(hit), .h_op(h_op), .h_value(h_value),
    .h_periodic(h_periodic));

  tmr_update u_update (
    .s_vld(s_vld), .hit(hit), .h_op(h_op), .h_value(h_value), .h_periodic(h_periodic),
    .cur(rd_entry), .cur_exp(exp_q[s_idx]), .we(upd_we), .nxt(upd_entry),
    .exp_set(exp_set), .exp_clr(exp_clr), .kind(kind));

  // clearing pass writes zero entries at the pointer, then the sweep writes back
  assign wr_en    = init ? 1'b1 : upd_we;
  assign wr_addr  = init ? ptr : s_idx;
  assign wr_entry = init ? '0 : upd_entry;

  tmr_store #(.DEPTH(NUM_TIMERS), .AW(IDX_W)) u_store (
    .clk(clk), .rd_addr(ptr), .rd_data(rd_entry),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_entry));

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q    <= '0;
      ev_valid <= 1'b0;
      ev_idx   <= '0;
      ev_kind  <= EV_NONE;
    end else begin
      if (exp_set)      exp_q[s_idx] <= 1'b1;
      else if (exp_clr) exp_q[s_idx] <= 1'b0;
      ev_valid <= (kind != EV_NONE);
      ev_idx   <= s_idx;
      ev_kind  <= kind;
    end
  end

  logic [WORD_W-1:0]    words [NW];
  logic [PAGE_SIZE-1:0] pages [NP];

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign words[w] = exp_q[w*WORD_W +: WORD_W];
  end
  for (genvar p = 0; p < NP; p++) begin : g_page
    assign pages[p] = exp_q[p*PAGE_SIZE +: PAGE_SIZE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_word <= '0;
      page_word <= '0;
    end else begin
      stat_word <= words[stat_sel];
      page_word <= pages[page_sel];
    end
  end

  AST_EXPIRE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_kind == EV_EXPIRE |-> exp_q[ev_idx]); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_kind == EV_STOP |-> !exp_q[ev_idx]); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_kind == EV_RESET |-> !exp_q[ev_idx]); // R7
  AST_PULSE_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    ev_valid && $past(ev_valid) |-> ev_idx != $past(ev_idx)); // R11
  AST_NO_EVENT_IN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    init |-> !ev_valid && !cmd_ready); // R1
endmodule

// File: tb/sweep_timer_mgr_bench.sv
module sweep_timer_mgr_bench;
  localparam int N = 64;
  localparam int IW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready, cmd_periodic = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [IW-1:0] cmd_idx = '0;
  logic [31:0] cmd_value = '0;
  logic ev_valid;
  logic [IW-1:0] ev_idx;
  logic [1:0] ev_kind;
  logic stat_sel = 1'b0;
  logic [31:0] stat_word;
  logic [1:0] page_sel = '0;
  logic [15:0] page_word;

  sweep_timer_mgr u_sweep_timer_mgr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_value(cmd_value), .cmd_periodic(cmd_periodic),
    .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_kind(ev_kind), .stat_sel(stat_sel),
    .stat_word(stat_word), .page_sel(page_sel), .page_word(page_word));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit done = 0;
  int n_exp[N], t_exp[N], n_rst[N], t_rst[N], n_stp[N], t_stp[N];
  int dup_err = 0;
  bit prev_v = 0;
  int prev_i = 0;

  always @(negedge clk) begin
    if (!rst && ev_valid) begin
      if (prev_v && prev_i == int'(ev_idx)) dup_err++;
      case (ev_kind)
        2'd1: begin n_exp[ev_idx]++; t_exp[ev_idx] = cyc; end
        2'd2: begin n_rst[ev_idx]++; t_rst[ev_idx] = cyc; end
        2'd3: begin n_stp[ev_idx]++; t_stp[ev_idx] = cyc; end
        default: dup_err++;
      endcase
    end
    prev_v = !rst && ev_valid;
    prev_i = int'(ev_idx);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input int op, input int idx, input longint val, input bit per,
                        output int c_done);
    int c_acc;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_idx = IW'(idx);
    cmd_value = 32'(val); cmd_periodic = per;
    @(negedge clk);
    c_acc = cyc;
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 ready drops", longint'(cmd_ready), 0);
    while (!cmd_ready) @(negedge clk);
    c_done = cyc;
    chk(c_done - c_acc <= N, "R2 apply bound", c_done - c_acc, N);
  endtask

  task automatic wait_exp(input int idx, input int prior, output int t);
    int k = 0;
    while (n_exp[idx] <= prior && k < 5*N + 8) begin @(negedge clk); k++; end
    @(negedge clk);
    t = t_exp[idx];
    chk(n_exp[idx] > prior, "R4 expiry seen", n_exp[idx], prior + 1);
  endtask

  task automatic read_stat(input int sel, input int pg, output logic [31:0] w,
                           output logic [15:0] p);
    @(negedge clk);
    stat_sel = sel[0]; page_sel = pg[1:0];
    @(negedge clk);
    w = stat_word; p = page_word;
  endtask

  function automatic int exp_gap(input int v);
    return ((v == 0) ? 1 : v) * N;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c, c0, t, t1, t2, t3, pe, ps, pr, idx, v;
    bit per;
    logic [31:0] w;
    logic [15:0] p;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < N; i++) begin
      n_exp[i] = 0; n_rst[i] = 0; n_stp[i] = 0; t_exp[i] = 0; t_rst[i] = 0; t_stp[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    c0 = cyc;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 ready low in clear", longint'(cmd_ready), 0);
    while (!cmd_ready && cyc - c0 < 4*N) @(negedge clk);
    chk(cyc - c0 == N, "R1 clear length", cyc - c0, N);
    chk(dup_err == 0 && n_exp[0] == 0, "R1 no event", dup_err, 0);
    for (int s = 0; s < 2; s++) begin
      read_stat(s, s, w, p);
      chk(w == 0 && p == 0, "R1 status zero", w, 0);
    end

    // one-shot, V=3
    do_cmd(0, 5, 3, 0, c);
    do_cmd(1, 5, 0, 0, c);
    wait_exp(5, 0, t);
    chk(t - c == exp_gap(3), "R4 one-shot timing", t - c, exp_gap(3));
    read_stat(0, 0, w, p);
    chk(w == 32'h20, "R10 word bit", w, 32'h20);
    chk(p == 16'h20, "R10 page bit", p, 16'h20);
    repeat (3*N) @(negedge clk);
    chk(n_exp[5] == 1, "R4 one-shot stays stopped", n_exp[5], 1);

    // stop on expired
    do_cmd(2, 5, 0, 0, c);
    @(negedge clk);
    chk(n_stp[5] == 1 && t_stp[5] == c, "R6 stop event", t_stp[5], c);
    read_stat(0, 0, w, p);
    chk(w == 0, "R6 flag cleared", w, 0);

    // periodic, V=2
    do_cmd(0, 40, 2, 1, c);
    do_cmd(1, 40, 0, 0, c);
    wait_exp(40, 0, t1);
    chk(t1 - c == exp_gap(2), "R5 first expiry", t1 - c, exp_gap(2));
    wait_exp(40, 1, t2);
    chk(t2 - t1 == exp_gap(2), "R5 period", t2 - t1, exp_gap(2));
    read_stat(1, 2, w, p);
    chk(w == 32'h100, "R10 upper word", w, 32'h100);
    chk(p == 16'h100, "R10 page two", p, 16'h100);

    // host command consumes a visit
    do_cmd(1, 40, 0, 0, c);
    wait_exp(40, 2, t3);
    chk(t3 - t2 == 3*N, "R9 visit consumed", t3 - t2, 3*N);

    // reset on expired periodic timer
    pr = n_rst[40];
    do_cmd(3, 40, 0, 0, c);
    @(negedge clk);
    chk(n_rst[40] == pr + 1 && t_rst[40] == c, "R7 reset event", t_rst[40], c);
    pe = n_exp[40];
    wait_exp(40, pe, t);
    chk(t - c == exp_gap(2), "R7 reload restart", t - c, exp_gap(2));

    // reset with flag clear: no event
    do_cmd(2, 40, 0, 0, c);      // stop while flag set
    do_cmd(3, 40, 0, 0, c);      // restart, flag now clear
    @(negedge clk);
    chk(n_rst[40] == pr + 1, "R7 no event when clear", n_rst[40], pr + 1);
    ps = n_stp[40];
    do_cmd(2, 40, 0, 0, c);      // stop before expiry
    pe = n_exp[40];
    repeat (3*N) @(negedge clk);
    chk(n_stp[40] == ps && n_exp[40] == pe, "R6 quiet stop", n_exp[40], pe);

    // load leaves expired flag, start uses new value
    do_cmd(0, 7, 1, 0, c);
    do_cmd(3, 7, 0, 0, c);
    wait_exp(7, 0, t);
    chk(t - c == exp_gap(1), "R7 reset starts", t - c, exp_gap(1));
    do_cmd(0, 7, 2, 0, c);
    read_stat(0, 0, w, p);
    chk(w[7] == 1'b1, "R8 load keeps flag", w[7], 1);
    repeat (2*N) @(negedge clk);
    chk(n_exp[7] == 1, "R8 load stops timer", n_exp[7], 1);
    do_cmd(1, 7, 0, 0, c);
    wait_exp(7, 1, t);
    chk(t - c == exp_gap(2), "R8 new period", t - c, exp_gap(2));

    // zero value acts as one
    do_cmd(0, 63, 0, 0, c);
    do_cmd(1, 63, 0, 0, c);
    wait_exp(63, 0, t);
    chk(t - c == N, "R4 zero value", t - c, N);

    // adjacent timers expire on back-to-back clocks
    do_cmd(0, 20, 1, 0, c);
    do_cmd(0, 21, 1, 0, c);
    do_cmd(1, 20, 0, 0, t1);
    do_cmd(1, 21, 0, 0, t2);
    wait_exp(21, 0, t);
    chk(n_exp[20] == 1 && n_exp[21] == 1, "R11 separate pulses", n_exp[20] + n_exp[21], 2);
    chk(t_exp[21] - t_exp[20] == t2 - t1, "R11 ordering", t_exp[21] - t_exp[20], t2 - t1);

    // random timers
    for (int k = 0; k < 8; k++) begin
      idx = 24 + ($urandom % 14);
      if (k % 2 == 1) idx = idx + 20;
      v = 1 + ($urandom % 4);
      per = $urandom % 2;
      pe = n_exp[idx];
      do_cmd(0, idx, v, per, c);
      do_cmd(1, idx, 0, 0, c);
      wait_exp(idx, pe, t);
      chk(t - c == exp_gap(v), "R4 random timing", t - c, exp_gap(v));
      read_stat(idx / 32, idx / 16, w, p);
      chk(w[idx % 32] == 1'b1 && p[idx % 16] == 1'b1, "R10 random bit", w, idx);
      if (per) begin
        wait_exp(idx, pe + 1, t1);
        chk(t1 - t == exp_gap(v), "R5 random period", t1 - t, exp_gap(v));
      end
      ps = n_stp[idx];
      do_cmd(2, idx, 0, 0, c);
      @(negedge clk);
      chk(n_stp[idx] == ps + 1, "R6 random stop", n_stp[idx], ps + 1);
    end

    chk(dup_err == 0, "R11 pulse shape", dup_err, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule